// File: doc/BRIEF.md
# PWM Dither Accumulator

This block gives a PWM timer a fractional step of one sixteenth of a count. Once per PWM period, on the end-of-cycle pulse, it adds a 4-bit dither increment into a 4-bit phase accumulator. When an addition carries out of the accumulator, the block raises an extend flag for the period that follows. The PWM engine uses that flag to make the selected on-time or dead-time one count longer. An increment of N therefore makes N periods out of every 16 one count longer, so the average edge position moves by N/16 of a count.

The increment is double buffered. Software writes a staging register, and the value moves into the working register only when the timer raises its update strobe. A 2-bit target code chooses which interval the flag lengthens: the on-time or the dead-time, of ramp B alone or of ramps A and B together. The accumulator is cleared when the timer is disabled or restarted.

Every pin is a plain control or status pin. No stream of data crosses the boundary, so there is no valid/ready handshake and nothing can stall the block. A write is taken on every cycle that its strobe is high.

Top module: `pwm_dither`

## Requirements
- R1: After reset, all four extend flags are low. The accumulator, the staged increment and the working increment are all zero.
- R2: With a working increment of N (0 to 15) and the target held, exactly N of any 16 consecutive counted periods carry an extend flag on ramp B.
- R3: A period is counted when `eoc_i` is high with `tmr_en_i` high and `restart_i` low. On a counted period, the working increment is added to the accumulator modulo 16, and the remainder is kept for the next period. A flag is raised only when that addition carries out of bit 3.
- R4: The flags are registered on the clock edge that samples a counted `eoc_i`. They then hold unchanged until the next counted period, even if `tgt_sel_i` changes in between.
- R5: The target code is sampled at the counted period. Its values are: 0 lengthens the on-time of ramp B; 1 lengthens the on-time of ramps A and B; 2 lengthens the dead-time of ramp B; 3 lengthens the dead-time of ramps A and B.
- R6: For target codes 0 and 2, the ramp A flags stay low even when the addition carries.
- R7: A write (`dith_wr_i` high) loads only the staging register. The accumulation keeps using the previous working increment until an update.
- R8: `dith_upd_i` copies the staging value held before that clock edge into the working register. A counted period in the same cycle still uses the old working increment. A write in the same cycle as an update is not copied by that update.
- R9: While `tmr_en_i` is low, the accumulator and all flags are cleared by the next edge, and `eoc_i` is ignored.
- R10: `restart_i` clears the accumulator and all flags on the next edge, and takes priority over an `eoc_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en_i | input | 1 | Timer running; low clears the accumulator and flags |
| restart_i | input | 1 | Timer restart pulse; clears the accumulator and flags |
| eoc_i | input | 1 | End-of-PWM-period pulse, one clock wide |
| dith_wr_i | input | 1 | Write strobe for the staging register |
| dith_wdata_i | input | 4 | Dither increment to stage |
| dith_upd_i | input | 1 | Update strobe: staging to working register |
| tgt_sel_i | input | 2 | Target code, see R5 |
| ext_on_a_o | output | 1 | Lengthen ramp A on-time this period |
| ext_on_b_o | output | 1 | Lengthen ramp B on-time this period |
| ext_dt_a_o | output | 1 | Lengthen ramp A dead-time this period |
| ext_dt_b_o | output | 1 | Lengthen ramp B dead-time this period |

## Verification
The stimulus runs several fixed increments over blocks of 16 periods. Increments 0, 5 and 15 check the density rule and the kept remainder, and they distinguish a wrapping accumulator from one that saturates or clears after each carry. The target code steps through all four values, so a swap between on-time and dead-time, or between one ramp and two, shows up at the outputs. Further patterns place a write without an update, an update in the same cycle as an end-of-cycle pulse, and a disable or restart in the middle of an accumulation. Each of these would change the carry pattern of the periods that follow if the buffering or clearing were wrong.

// File: rtl/pwm_dith_pkg.sv
package pwm_dith_pkg;

  typedef enum logic [1:0] {
    TGT_ON_B  = 2'd0,
    TGT_ON_AB = 2'd1,
    TGT_DT_B  = 2'd2,
    TGT_DT_AB = 2'd3
  } dith_tgt_e;

  localparam int unsigned RAMP_CNT = 2;
  localparam int unsigned RAMP_B   = 0;
  localparam int unsigned RAMP_A   = 1;

endpackage

// File: rtl/dith_shadow.sv
module dith_shadow #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         upd_i,
  output logic [W-1:0] act_o
);

  logic [W-1:0] stage_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (wr_i) begin
      stage_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (upd_i) begin
      act_q <= stage_q;
    end
  end

  assign act_o = act_q;

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(act_q));

  // R8
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> act_q == $past(stage_q));

endmodule

// File: rtl/dith_accum.sv
module dith_accum #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] inc_i,
  output logic         carry_o
);

  localparam int unsigned SW = W + 1;

  logic [W-1:0]  acc_q;
  logic [SW-1:0] sum;

  assign sum     = {1'b0, acc_q} + {1'b0, inc_i};
  assign carry_o = step_i & sum[SW-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      acc_q <= '0;
    end else if (step_i) begin
      acc_q <= sum[W-1:0];
    end
  end

  // R9 R10
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_q == '0);

  // R3
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !step_i) |=> $stable(acc_q));

endmodule

// File: rtl/dith_route.sv
module dith_route
  import pwm_dith_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                load_i,
  input  logic                carry_i,
  input  dith_tgt_e           tgt_i,
  output logic [RAMP_CNT-1:0] ext_on_o,
  output logic [RAMP_CNT-1:0] ext_dt_o
);

  logic want_dt;
  assign want_dt = (tgt_i == TGT_DT_B) || (tgt_i == TGT_DT_AB);

  for (genvar r = 0; r < RAMP_CNT; r++) begin : g_ramp
    logic ramp_sel;
    logic on_q;
    logic dt_q;

    if (r == RAMP_B) begin : g_b
      assign ramp_sel = 1'b1;
    end else begin : g_a
      assign ramp_sel = (tgt_i == TGT_ON_AB) || (tgt_i == TGT_DT_AB);
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
        on_q <= 1'b0;
        dt_q <= 1'b0;
      end else if (load_i) begin
        on_q <= carry_i && ramp_sel && !want_dt;
        dt_q <= carry_i && ramp_sel &&  want_dt;
      end
    end

    assign ext_on_o[r] = on_q;
    assign ext_dt_o[r] = dt_q;
  end

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i) |=> ($stable(ext_on_o) && $stable(ext_dt_o)));

endmodule

// File: rtl/pwm_dither.sv
module pwm_dither
  import pwm_dith_pkg::*;
#(
  parameter int unsigned DITH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en_i,
  input  logic              restart_i,
  input  logic              eoc_i,
  input  logic              dith_wr_i,
  input  logic [DITH_W-1:0] dith_wdata_i,
  input  logic              dith_upd_i,
  input  logic [1:0]        tgt_sel_i,
  output logic              ext_on_a_o,
  output logic              ext_on_b_o,
  output logic              ext_dt_a_o,
  output logic              ext_dt_b_o
);

  logic              clr;
  logic              step;
  logic              carry;
  logic [DITH_W-1:0] inc_act;
  logic [RAMP_CNT-1:0] ext_on;
  logic [RAMP_CNT-1:0] ext_dt;

  assign clr  = !tmr_en_i || restart_i;
  assign step = eoc_i && !clr;

  dith_shadow #(.W(DITH_W)) i_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (dith_wr_i),
    .wdata_i (dith_wdata_i),
    .upd_i   (dith_upd_i),
    .act_o   (inc_act)
  );

  dith_accum #(.W(DITH_W)) i_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .step_i  (step),
    .inc_i   (inc_act),
    .carry_o (carry)
  );

  dith_route i_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .load_i   (step),
    .carry_i  (carry),
    .tgt_i    (dith_tgt_e'(tgt_sel_i)),
    .ext_on_o (ext_on),
    .ext_dt_o (ext_dt)
  );

  assign ext_on_a_o = ext_on[RAMP_A];
  assign ext_on_b_o = ext_on[RAMP_B];
  assign ext_dt_a_o = ext_dt[RAMP_A];
  assign ext_dt_b_o = ext_dt[RAMP_B];

  // R6
  ramp_a_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_on_a_o |-> ext_on_b_o) and (ext_dt_a_o |-> ext_dt_b_o)));

  // R5
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_on_b_o, ext_dt_b_o}));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en_i |=> !(ext_on_a_o || ext_on_b_o || ext_dt_a_o || ext_dt_b_o));

  // R10
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !(ext_on_a_o || ext_on_b_o || ext_dt_a_o || ext_dt_b_o));

endmodule

// File: tb/test_pwm_dither.sv
`timescale 1ns/1ps
module test_pwm_dither;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       restart = 1'b0;
  logic       eoc = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] wdata = '0;
  logic       upd = 1'b0;
  logic [1:0] tgt = '0;
  logic       on_a, on_b, dt_a, dt_b;
  logic [3:0] flags;

  assign flags = {dt_a, dt_b, on_a, on_b};

  always #2.5 clk = ~clk;

  pwm_dither i_pwm_dither (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_en_i     (en),
    .restart_i    (restart),
    .eoc_i        (eoc),
    .dith_wr_i    (wr),
    .dith_wdata_i (wdata),
    .dith_upd_i   (upd),
    .tgt_sel_i    (tgt),
    .ext_on_a_o   (on_a),
    .ext_on_b_o   (on_b),
    .ext_dt_a_o   (dt_a),
    .ext_dt_b_o   (dt_b)
  );

  int vecs = 0;
  int errs = 0;
  int ext_cnt = 0;
  bit done = 1'b0;

  // Reference state, kept from the requirements alone
  int m_stage = 0;
  int m_act = 0;
  int m_acc = 0;
  logic [3:0] last_exp = '0;
  logic [3:0] exp_q[$];

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Flag encoding {dt_a, dt_b, on_a, on_b}; targets per R5, ramp A masking per R6
  function automatic logic [3:0] expect_flags(input logic c, input logic [1:0] s);
    logic [3:0] e;
    e[0] = c && (s == 2'd0 || s == 2'd1);
    e[1] = c && (s == 2'd1);
    e[2] = c && (s == 2'd2 || s == 2'd3);
    e[3] = c && (s == 2'd3);
    return e;
  endfunction

  // Scoreboard monitor: one expected item per counted period (R3 R5)
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && eoc && en && !restart) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          errs++;
          vecs++;
          $display("FAIL R3 actual=%b expected=<none queued>", flags);
        end else begin
          check("R3 R5 period flags", flags, exp_q.pop_front());
        end
        if (on_b || dt_b) ext_cnt++;
      end
    end
  end

  task automatic stage(input int v);
    @(negedge clk);
    wr = 1'b1; wdata = 4'(v);
    @(negedge clk);
    wr = 1'b0;
    m_stage = v;
  endtask

  task automatic update();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    m_act = m_stage;
  endtask

  // One PWM period of len clocks; optional update in the eoc cycle (R8)
  task automatic period(input logic [1:0] s, input int len, input bit with_upd);
    int sum;
    logic [3:0] e;
    @(negedge clk);
    tgt = s; eoc = 1'b1; upd = with_upd;
    sum = m_acc + m_act;
    e = expect_flags(sum > 15, s);
    m_acc = sum % 16;
    exp_q.push_back(e);
    last_exp = e;
    if (with_upd) m_act = m_stage;
    @(negedge clk);
    eoc = 1'b0; upd = 1'b0;
    tgt = ~s;
    repeat (len - 1) @(negedge clk);
    // R4: flags held through the period despite the select change
    check("R4 hold", flags, last_exp);
  endtask

  task automatic block16(input int v, input logic [1:0] s, input string req);
    ext_cnt = 0;
    for (int i = 0; i < 16; i++) period(s, 3, 1'b0);
    check_int(req, ext_cnt, v);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset flags", flags, 4'b0000);
    en = 1'b1;

    // R1: working increment is zero after reset, so no flags
    period(2'd0, 2, 1'b0);

    // R2: density for N = 5, 0 and 15
    stage(5); update();
    block16(5, 2'd0, "R2 count N=5");
    stage(0); update();
    block16(0, 2'd0, "R2 count N=0");
    stage(15); update();
    block16(15, 2'd2, "R2 count N=15");

    // R5 R6: every target code
    stage(11); update();
    for (int i = 0; i < 12; i++) period(2'(i % 4), 2, 1'b0);

    // R7: staging write without update has no effect
    stage(3);
    for (int i = 0; i < 5; i++) period(2'd1, 2, 1'b0);

    // R8: update in the eoc cycle; old increment used for that period
    stage(9);
    period(2'd3, 2, 1'b1);
    for (int i = 0; i < 4; i++) period(2'd3, 2, 1'b0);
    // R8: write and update in the same cycle copies the previous staging value
    @(negedge clk);
    wr = 1'b1; wdata = 4'd1; upd = 1'b1;
    @(negedge clk);
    wr = 1'b0; upd = 1'b0;
    m_act = m_stage; m_stage = 1;
    for (int i = 0; i < 4; i++) period(2'd1, 2, 1'b0);

    // R9: disable clears flags and accumulator; eoc ignored meanwhile
    stage(15); update();
    period(2'd0, 2, 1'b0);
    period(2'd0, 2, 1'b0);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R9 disable flags", flags, 4'b0000);
    eoc = 1'b1;
    @(negedge clk);
    eoc = 1'b0;
    check("R9 eoc ignored", flags, 4'b0000);
    en = 1'b1;
    m_acc = 0;
    period(2'd0, 2, 1'b0);
    period(2'd0, 2, 1'b0);

    // R10: restart with eoc in the same cycle clears and wins
    period(2'd1, 2, 1'b0);
    @(negedge clk);
    restart = 1'b1; eoc = 1'b1;
    @(negedge clk);
    restart = 1'b0; eoc = 1'b0;
    check("R10 restart flags", flags, 4'b0000);
    m_acc = 0;
    period(2'd1, 2, 1'b0);
    period(2'd1, 2, 1'b0);

    check_int("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule